// File: doc/BRIEF.md
# Dual-Path Reference Clock Selector

This block decides which external reference each of two clock-recovery paths should try to lock to. It does not switch clocks. It only produces, for each path, a registered input index and a mode code. The actual multiplexer and the loops downstream act on those outputs.

The primary path has three ways to choose. In fast-switch mode it picks one member of a strap-chosen input pair. In forced mode a configuration code names the input. In automatic mode the best qualified input is chosen by priority. The secondary path can be forced or automatic, or it can follow the primary path's recovered output at either the high or the low rate. Quality flags come from an external monitor. Each path has its own priority set.

Inputs are numbered 1 to N_IN (8 by default). Input 1 and input 2 form pair 1: input 1 is the single-ended member and input 2 the differential member. Inputs 3 and 4 form pair 2 in the same way. Select code 0 means automatic. Codes 9 to 15 are reserved.

Top module: `refsel_top`

## Requirements
- R1: When the fast-switch enable is 1, the primary path is in fast mode (`pri_mode_o` = 2), and `pri_sel_i` has no effect on the selection.
- R2: When the fast-switch enable is 0, a `pri_sel_i` value of 1..8 gives forced mode (`pri_mode_o` = 1) with `pri_idx_o` equal to that value, and the quality flags are ignored. A value of 0 gives automatic mode (`pri_mode_o` = 0).
- R3: When `sec_follow_i` is 0, a `sec_sel_i` value of 1..8 forces the secondary path to that input (`sec_mode_o` = 1). A value of 0 gives automatic mode (`sec_mode_o` = 0).
- R4: While `rst_n` is low, the fast-switch enable loads from `strap_fast_i`. After reset it changes only through a `fast_en_wr_i` pulse, which writes `fast_en_val_i`. The selection outputs reflect the new value two clock edges after the pulse.
- R5: In fast mode, a strap level of 1 latched during reset selects pair 1 (inputs 1 and 2), and a level of 0 selects pair 2 (inputs 3 and 4). If the single-ended member's primary priority (input 1 or input 3) is 0000, the differential member (input 2 or input 4) is chosen. Any other value chooses the single-ended member.
- R6: In fast mode, the quality flags do not affect the selection, and `pri_noref_o` stays 0.
- R7: When `sec_follow_i` is 1, the secondary path follows the primary output and `sec_idx_o` is 0. `sec_mode_o` is 2 when `sec_follow_8k_i` is 0 (77.76 MHz) and 3 when it is 1 (8 kHz). `sec_sel_i` is ignored.
- R8: In automatic mode, a path selects the qualified input with the lowest nonzero priority, and ties go to the lower index. Priority 0000 disables an input. Priority of input k sits at bits [4k-1:4k-4] and its quality flag at bit k-1. If no input qualifies, the no-reference flag is 1 and the index keeps its previous value.
- R9: Every output is registered and reflects the inputs of the previous clock edge. `chg_o` is high for exactly the cycles in which either path's index differs from its value one cycle before.
- R10: A select code of 9..15 on a path that is not overridden makes that path behave as automatic and sets that path's error flag. The flag stays set while the code remains and clears on the edge after a valid code is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_fast_i | input | 1 | Fast-switch strap level, sampled during reset |
| fast_en_wr_i | input | 1 | Write strobe for the fast-switch enable |
| fast_en_val_i | input | 1 | Value written to the fast-switch enable |
| pri_sel_i | input | 4 | Primary select code (0 = automatic) |
| sec_sel_i | input | 4 | Secondary select code (0 = automatic) |
| sec_follow_i | input | 1 | Secondary path follows the primary output |
| sec_follow_8k_i | input | 1 | Follow rate: 0 = 77.76 MHz, 1 = 8 kHz |
| pri_prio_i | input | 32 | Primary priorities, 4 bits per input |
| sec_prio_i | input | 32 | Secondary priorities, 4 bits per input |
| qual_i | input | 8 | Per-input quality-valid flags |
| pri_idx_o | output | 4 | Primary selected input |
| pri_mode_o | output | 2 | Primary mode: 0 auto, 1 forced, 2 fast |
| pri_noref_o | output | 1 | Primary has no qualified reference |
| pri_cfg_err_o | output | 1 | Primary select code is reserved |
| sec_idx_o | output | 4 | Secondary selected input (0 when following) |
| sec_mode_o | output | 2 | Secondary mode: 0 auto, 1 forced, 2 follow high, 3 follow low |
| sec_noref_o | output | 1 | Secondary has no qualified reference |
| sec_cfg_err_o | output | 1 | Secondary select code is reserved |
| chg_o | output | 1 | Either selected index changed |

## Verification
Two things can happen on the same clock edge: the change strobe and the no-reference hold. When one path loses all its qualified inputs and keeps its index, the other path can move in that same cycle. The vector table provokes this by dropping every qualification while the secondary path switches to follow mode. The check then expects `chg_o` high, with the primary index unchanged and its no-reference flag set. A second coincidence is a reserved code on both paths in the same cycle. Each error flag must then rise on its own while both paths run automatic arbitration.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

   typedef enum logic [1:0] {
      PM_AUTO   = 2'd0,
      PM_FORCED = 2'd1,
      PM_FAST   = 2'd2
   } pri_mode_e;

   typedef enum logic [1:0] {
      SM_AUTO      = 2'd0,
      SM_FORCED    = 2'd1,
      SM_FOLLOW_HI = 2'd2,
      SM_FOLLOW_LO = 2'd3
   } sec_mode_e;

endpackage

// File: rtl/refsel_arbiter.sv
module refsel_arbiter #(
   parameter int N_IN           = 8,
   parameter int PRIO_W         = 4,
   parameter int IDX_W          = 4,
   parameter bit LOW_INDEX_WINS = 1'b1
) (
   input  logic [N_IN*PRIO_W-1:0] prio_i,
   input  logic [N_IN-1:0]        qual_i,
   output logic                   found_o,
   output logic [IDX_W-1:0]       idx_o
);

   logic [PRIO_W-1:0] prio_a [N_IN];

   // unpack the flat priority bus, one field per input
   for (genvar g = 0; g < N_IN; g++) begin : g_unpack
      assign prio_a[g] = prio_i[g*PRIO_W +: PRIO_W];
   end

   logic [PRIO_W-1:0] best;

   always_comb begin
      found_o = 1'b0;
      best    = '1;
      idx_o   = '0;
      for (int i = 0; i < N_IN; i++) begin
         if (qual_i[i] && (prio_a[i] != '0)) begin
            if (!found_o ||
                (LOW_INDEX_WINS ? (prio_a[i] < best) : (prio_a[i] <= best))) begin
               found_o = 1'b1;
               best    = prio_a[i];
               idx_o   = IDX_W'(i + 1);
            end
         end
      end
   end

endmodule

// File: rtl/refsel_pri_path.sv
module refsel_pri_path
   import refsel_pkg::*;
#(
   parameter int N_IN   = 8,
   parameter int PRIO_W = 4,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fast_en_i,
   input  logic              pair1_i,
   input  logic [IDX_W-1:0]  sel_i,
   input  logic [PRIO_W-1:0] prio_se1_i,
   input  logic [PRIO_W-1:0] prio_se2_i,
   input  logic              arb_found_i,
   input  logic [IDX_W-1:0]  arb_idx_i,
   output logic [IDX_W-1:0]  idx_nxt_o,
   output logic [IDX_W-1:0]  idx_o,
   output pri_mode_e         mode_o,
   output logic              noref_o,
   output logic              err_o
);

   localparam logic [IDX_W-1:0] IDX_SE1 = IDX_W'(1);
   localparam logic [IDX_W-1:0] IDX_DF1 = IDX_W'(2);
   localparam logic [IDX_W-1:0] IDX_SE2 = IDX_W'(3);
   localparam logic [IDX_W-1:0] IDX_DF2 = IDX_W'(4);
   localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(N_IN);

   pri_mode_e mode_n;
   logic      noref_n;
   logic      err_n;
   logic      sel_ok;

   assign sel_ok = (sel_i != '0) && (sel_i <= IDX_MAX);

   always_comb begin
      mode_n    = PM_AUTO;
      noref_n   = 1'b0;
      err_n     = 1'b0;
      idx_nxt_o = idx_o;
      if (fast_en_i) begin
         mode_n = PM_FAST;
         if (pair1_i) idx_nxt_o = (prio_se1_i == '0) ? IDX_DF1 : IDX_SE1;
         else         idx_nxt_o = (prio_se2_i == '0) ? IDX_DF2 : IDX_SE2;
      end else if (sel_ok) begin
         mode_n    = PM_FORCED;
         idx_nxt_o = sel_i;
      end else begin
         err_n = (sel_i != '0);
         if (arb_found_i) idx_nxt_o = arb_idx_i;
         else             noref_n   = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_o   <= '0;
         mode_o  <= PM_AUTO;
         noref_o <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         idx_o   <= idx_nxt_o;
         mode_o  <= mode_n;
         noref_o <= noref_n;
         err_o   <= err_n;
      end
   end

   AST_PRI_FORCED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == PM_FORCED) |-> (idx_o != '0 && idx_o <= IDX_MAX));  // R2
   AST_PRI_NOREF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      noref_o |-> (idx_o == $past(idx_o)));  // R8
   AST_PRI_FAST_NOREF: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == PM_FAST) |-> !noref_o);  // R6
   AST_PRI_ERR_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (mode_o == PM_AUTO));  // R10

endmodule

// File: rtl/refsel_sec_path.sv
module refsel_sec_path
   import refsel_pkg::*;
#(
   parameter int N_IN  = 8,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             follow_i,
   input  logic             follow_8k_i,
   input  logic [IDX_W-1:0] sel_i,
   input  logic             arb_found_i,
   input  logic [IDX_W-1:0] arb_idx_i,
   output logic [IDX_W-1:0] idx_nxt_o,
   output logic [IDX_W-1:0] idx_o,
   output sec_mode_e        mode_o,
   output logic             noref_o,
   output logic             err_o
);

   localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(N_IN);

   sec_mode_e mode_n;
   logic      noref_n;
   logic      err_n;
   logic      sel_ok;

   assign sel_ok = (sel_i != '0) && (sel_i <= IDX_MAX);

   always_comb begin
      mode_n    = SM_AUTO;
      noref_n   = 1'b0;
      err_n     = 1'b0;
      idx_nxt_o = idx_o;
      if (follow_i) begin
         mode_n    = follow_8k_i ? SM_FOLLOW_LO : SM_FOLLOW_HI;
         idx_nxt_o = '0;
      end else if (sel_ok) begin
         mode_n    = SM_FORCED;
         idx_nxt_o = sel_i;
      end else begin
         err_n = (sel_i != '0);
         if (arb_found_i) idx_nxt_o = arb_idx_i;
         else             noref_n   = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_o   <= '0;
         mode_o  <= SM_AUTO;
         noref_o <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         idx_o   <= idx_nxt_o;
         mode_o  <= mode_n;
         noref_o <= noref_n;
         err_o   <= err_n;
      end
   end

   AST_SEC_FOLLOW_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == SM_FOLLOW_HI || mode_o == SM_FOLLOW_LO) |-> (idx_o == '0));  // R7
   AST_SEC_NOREF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      noref_o |-> (idx_o == $past(idx_o)));  // R8
   AST_SEC_FORCED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == SM_FORCED) |-> (idx_o != '0 && idx_o <= IDX_MAX));  // R3
   AST_SEC_ERR_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (mode_o == SM_AUTO));  // R10

endmodule

// File: rtl/refsel_top.sv
module refsel_top
   import refsel_pkg::*;
#(
   parameter int N_IN   = 8,
   parameter int PRIO_W = 4,
   parameter int IDX_W  = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   strap_fast_i,
   input  logic                   fast_en_wr_i,
   input  logic                   fast_en_val_i,
   input  logic [IDX_W-1:0]       pri_sel_i,
   input  logic [IDX_W-1:0]       sec_sel_i,
   input  logic                   sec_follow_i,
   input  logic                   sec_follow_8k_i,
   input  logic [N_IN*PRIO_W-1:0] pri_prio_i,
   input  logic [N_IN*PRIO_W-1:0] sec_prio_i,
   input  logic [N_IN-1:0]        qual_i,
   output logic [IDX_W-1:0]       pri_idx_o,
   output logic [1:0]             pri_mode_o,
   output logic                   pri_noref_o,
   output logic                   pri_cfg_err_o,
   output logic [IDX_W-1:0]       sec_idx_o,
   output logic [1:0]             sec_mode_o,
   output logic                   sec_noref_o,
   output logic                   sec_cfg_err_o,
   output logic                   chg_o
);

   localparam int SE2_LSB = 2 * PRIO_W;

   // elaboration-time parameter checks
   if (N_IN < 4) begin : g_chk_pairs
      $error("refsel_top: N_IN must cover both fast-switch pairs");
   end
   if (N_IN > (2**IDX_W) - 1) begin : g_chk_idx
      $error("refsel_top: IDX_W too narrow for N_IN");
   end
   if (PRIO_W < 1) begin : g_chk_prio
      $error("refsel_top: PRIO_W must be positive");
   end

   logic strap_q;
   logic fast_en_q;
   logic chg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strap_q   <= strap_fast_i;
         fast_en_q <= strap_fast_i;
      end else if (fast_en_wr_i) begin
         fast_en_q <= fast_en_val_i;
      end
   end

   logic             pa_found, sa_found;
   logic [IDX_W-1:0] pa_idx, sa_idx;

   refsel_arbiter #(.N_IN(N_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pri_arb (
      .prio_i (pri_prio_i),
      .qual_i (qual_i),
      .found_o(pa_found),
      .idx_o  (pa_idx)
   );

   refsel_arbiter #(.N_IN(N_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_sec_arb (
      .prio_i (sec_prio_i),
      .qual_i (qual_i),
      .found_o(sa_found),
      .idx_o  (sa_idx)
   );

   logic [IDX_W-1:0] p_nxt, s_nxt;
   pri_mode_e        p_mode;
   sec_mode_e        s_mode;

   refsel_pri_path #(.N_IN(N_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pri (
      .clk        (clk),
      .rst_n      (rst_n),
      .fast_en_i  (fast_en_q),
      .pair1_i    (strap_q),
      .sel_i      (pri_sel_i),
      .prio_se1_i (pri_prio_i[PRIO_W-1:0]),
      .prio_se2_i (pri_prio_i[SE2_LSB +: PRIO_W]),
      .arb_found_i(pa_found),
      .arb_idx_i  (pa_idx),
      .idx_nxt_o  (p_nxt),
      .idx_o      (pri_idx_o),
      .mode_o     (p_mode),
      .noref_o    (pri_noref_o),
      .err_o      (pri_cfg_err_o)
   );

   refsel_sec_path #(.N_IN(N_IN), .IDX_W(IDX_W)) u_sec (
      .clk        (clk),
      .rst_n      (rst_n),
      .follow_i   (sec_follow_i),
      .follow_8k_i(sec_follow_8k_i),
      .sel_i      (sec_sel_i),
      .arb_found_i(sa_found),
      .arb_idx_i  (sa_idx),
      .idx_nxt_o  (s_nxt),
      .idx_o      (sec_idx_o),
      .mode_o     (s_mode),
      .noref_o    (sec_noref_o),
      .err_o      (sec_cfg_err_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) chg_q <= 1'b0;
      else        chg_q <= (p_nxt != pri_idx_o) || (s_nxt != sec_idx_o);
   end

   assign pri_mode_o = p_mode;
   assign sec_mode_o = s_mode;
   assign chg_o      = chg_q;

   AST_CHG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      chg_o |-> ((pri_idx_o != $past(pri_idx_o)) || (sec_idx_o != $past(sec_idx_o))));  // R9
   AST_NO_SILENT_CHG: assert property (@(posedge clk) disable iff (!rst_n)
      !chg_o |-> ((pri_idx_o == $past(pri_idx_o)) && (sec_idx_o == $past(sec_idx_o))));  // R9
   AST_FAST_PAIR_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (p_mode == PM_FAST) |->
         (strap_q ? (pri_idx_o == IDX_W'(1) || pri_idx_o == IDX_W'(2))
                  : (pri_idx_o == IDX_W'(3) || pri_idx_o == IDX_W'(4))));  // R5

endmodule

// File: tb/tb_refsel_top.sv
module tb_refsel_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        strap;
   logic        fe_wr, fe_val;
   logic [3:0]  psel, ssel;
   logic        fol, f8k;
   logic [31:0] pprio, sprio;
   logic [7:0]  qual;
   logic [3:0]  pidx, sidx;
   logic [1:0]  pmode, smode;
   logic        pnoref, perr, snoref, serr, chg;

   int checks   = 0;
   int failures = 0;

   always #5 clk = ~clk;

   refsel_top dut (
      .clk(clk), .rst_n(rst_n), .strap_fast_i(strap),
      .fast_en_wr_i(fe_wr), .fast_en_val_i(fe_val),
      .pri_sel_i(psel), .sec_sel_i(ssel),
      .sec_follow_i(fol), .sec_follow_8k_i(f8k),
      .pri_prio_i(pprio), .sec_prio_i(sprio), .qual_i(qual),
      .pri_idx_o(pidx), .pri_mode_o(pmode), .pri_noref_o(pnoref), .pri_cfg_err_o(perr),
      .sec_idx_o(sidx), .sec_mode_o(smode), .sec_noref_o(snoref), .sec_cfg_err_o(serr),
      .chg_o(chg)
   );

   typedef struct packed {
      logic [3:0]  psel;  logic [3:0]  ssel;  logic fol;  logic f8k;
      logic [31:0] pprio; logic [31:0] sprio; logic [7:0] qual;
      logic [3:0]  e_pidx; logic [1:0] e_pmode; logic e_pnoref; logic e_perr;
      logic [3:0]  e_sidx; logic [1:0] e_smode; logic e_snoref; logic e_serr;
      logic        e_chg;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      // R8 lowest priority wins on both paths
      '{4'd0, 4'd0, 1'b0, 1'b0, 32'h8765_4321, 32'h1234_5678, 8'hFF,
        4'd1, 2'd0, 1'b0, 1'b0, 4'd8, 2'd0, 1'b0, 1'b0, 1'b1},
      // R8 unqualified input skipped
      '{4'd0, 4'd0, 1'b0, 1'b0, 32'h8765_4321, 32'h1234_5678, 8'hFE,
        4'd2, 2'd0, 1'b0, 1'b0, 4'd8, 2'd0, 1'b0, 1'b0, 1'b1},
      // R8 tie to lower index, all-disabled secondary holds; R9 no change
      '{4'd0, 4'd0, 1'b0, 1'b0, 32'h1111_1110, 32'h0000_0000, 8'hFF,
        4'd2, 2'd0, 1'b0, 1'b0, 4'd8, 2'd0, 1'b1, 1'b0, 1'b0},
      // R2 R3 forced ignores quality
      '{4'd5, 4'd3, 1'b0, 1'b0, 32'h1111_1110, 32'h0000_0000, 8'h00,
        4'd5, 2'd1, 1'b0, 1'b0, 4'd3, 2'd1, 1'b0, 1'b0, 1'b1},
      // R8 primary no-ref hold while R7 follow high moves secondary
      '{4'd0, 4'd3, 1'b1, 1'b0, 32'h1111_1110, 32'h0000_0000, 8'h00,
        4'd5, 2'd0, 1'b1, 1'b0, 4'd0, 2'd2, 1'b0, 1'b0, 1'b1},
      // R7 follow low
      '{4'd0, 4'd3, 1'b1, 1'b1, 32'h1111_1110, 32'h0000_0000, 8'h80,
        4'd8, 2'd0, 1'b0, 1'b0, 4'd0, 2'd3, 1'b0, 1'b0, 1'b1},
      // R10 reserved codes on both paths
      '{4'd9, 4'd15, 1'b0, 1'b0, 32'h2222_2223, 32'h1234_5678, 8'hFF,
        4'd2, 2'd0, 1'b0, 1'b1, 4'd8, 2'd0, 1'b0, 1'b1, 1'b1},
      // R10 rewrite clears error
      '{4'd8, 4'd1, 1'b0, 1'b0, 32'h2222_2223, 32'h1234_5678, 8'hFF,
        4'd8, 2'd1, 1'b0, 1'b0, 4'd1, 2'd1, 1'b0, 1'b0, 1'b1}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset(input logic s);
      @(negedge clk);
      rst_n = 1'b0;
      strap = s;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 1'b0; strap = 1'b0; fe_wr = 1'b0; fe_val = 1'b0;
      psel = '0; ssel = '0; fol = 1'b0; f8k = 1'b0;
      pprio = '0; sprio = '0; qual = '0;

      // reset state (R9 outputs registered, cleared)
      repeat (2) @(negedge clk);
      chk("R9 reset pri_idx", 32'(pidx), 0);
      chk("R9 reset sec_idx", 32'(sidx), 0);
      chk("R9 reset pri_mode", 32'(pmode), 0);
      chk("R9 reset chg", 32'(chg), 0);
      chk("R8 reset noref", 32'(pnoref | snoref), 0);
      do_reset(1'b0);

      for (int v = 0; v < NV; v++) begin
         psel = VECS[v].psel; ssel = VECS[v].ssel; fol = VECS[v].fol; f8k = VECS[v].f8k;
         pprio = VECS[v].pprio; sprio = VECS[v].sprio; qual = VECS[v].qual;
         step();
         chk($sformatf("R2/R8 v%0d pri_idx", v), 32'(pidx), 32'(VECS[v].e_pidx));
         chk($sformatf("R2 v%0d pri_mode", v), 32'(pmode), 32'(VECS[v].e_pmode));
         chk($sformatf("R8 v%0d pri_noref", v), 32'(pnoref), 32'(VECS[v].e_pnoref));
         chk($sformatf("R10 v%0d pri_err", v), 32'(perr), 32'(VECS[v].e_perr));
         chk($sformatf("R3/R7 v%0d sec_idx", v), 32'(sidx), 32'(VECS[v].e_sidx));
         chk($sformatf("R3/R7 v%0d sec_mode", v), 32'(smode), 32'(VECS[v].e_smode));
         chk($sformatf("R8 v%0d sec_noref", v), 32'(snoref), 32'(VECS[v].e_snoref));
         chk($sformatf("R10 v%0d sec_err", v), 32'(serr), 32'(VECS[v].e_serr));
         chk($sformatf("R9 v%0d chg", v), 32'(chg), 32'(VECS[v].e_chg));
      end

      // R9: strobe lasts one cycle
      step();
      chk("R9 strobe drops", 32'(chg), 0);

      // R4 R5 R6 R1: strap high, pair 1
      psel = 4'd5; pprio = 32'h0000_0000; qual = 8'h00;
      do_reset(1'b1);
      step();
      chk("R4 strap loads fast mode", 32'(pmode), 2);
      chk("R5 pair1 zero prio -> diff", 32'(pidx), 2);
      chk("R6 fast ignores quality", 32'(pnoref), 0);
      pprio = 32'h0000_0001;
      step();
      chk("R5 pair1 nonzero -> single", 32'(pidx), 1);
      chk("R1 select field ignored", 32'(pmode), 2);
      fe_wr = 1'b1; fe_val = 1'b0;
      step();
      fe_wr = 1'b0;
      chk("R4 one edge after write still fast", 32'(pmode), 2);
      step();
      chk("R4 write clears fast", 32'(pmode), 1);
      chk("R2 forced after write", 32'(pidx), 5);

      // R5 strap low, pair 2
      pprio = 32'h0000_0000;
      do_reset(1'b0);
      step();
      chk("R4 strap low not fast", 32'(pmode), 1);
      fe_wr = 1'b1; fe_val = 1'b1;
      step();
      fe_wr = 1'b0;
      step();
      chk("R4 write sets fast", 32'(pmode), 2);
      chk("R5 pair2 zero prio -> diff", 32'(pidx), 4);
      pprio = 32'h0000_0100;
      step();
      chk("R5 pair2 nonzero -> single", 32'(pidx), 3);
      qual = 8'hFF;
      pprio = 32'h0000_0111;
      step();
      chk("R6 quality change no effect", 32'(pidx), 3);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule